// File: doc/BRIEF.md
# Washing Machine Cycle Sequencer

The sequencer steps a washing machine through one fixed program of seven phases. It rests in an idle phase until a start pulse arrives. It then opens the inlet valve and waits until the water-level sensor reports a full drum. It runs the motor for a fixed wash time, and opens the drain valve until the drain sensor reports an empty drum. Next it runs the motor for a fixed rinse time and then at high speed for a fixed spin time. A completion phase follows, and the sequencer then returns to idle.

The three timed phases use a single shared phase counter. The counter clears on every change of phase. The fill and drain phases have no time limit and leave only on their sensor. The actuator outputs and the done flag are decoded from the registered phase alone, so they change together with the state code. The state code is brought out on its own port.

Top module: `wash_cycle_seq`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first cycle after it is released, the state code is 0 and every actuator output and `cycle_done` are low. The state code values are idle 0, fill 1, wash 2, drain 3, rinse 4, spin 5 and end 6. No other value ever appears.
- R2: In idle, a high `start` at a clock edge moves the state to fill at that edge. Without `start`, the state stays idle.
- R3: Fill is held until `water_full` is high at a clock edge. At that edge the state moves to wash.
- R4: Wash lasts exactly `WASH_CYC` clock cycles and is then followed by drain.
- R5: Drain is held until `drain_empty` is high at a clock edge. At that edge the state moves to rinse.
- R6: Rinse lasts exactly `RINSE_CYC` clock cycles and is then followed by spin.
- R7: Spin lasts exactly `SPIN_CYC` clock cycles and is then followed by end.
- R8: End lasts one cycle, and `cycle_done` is high during that cycle only. The following cycle is idle.
- R9: `inlet_on` is high only in fill and `drain_on` only in drain. `motor_on` is high in wash, rinse and spin, and `motor_fast` only in spin.
- R10: A `start` pulse in any phase other than idle has no effect on the sequence.
- R11: `water_full` outside fill and `drain_empty` outside drain have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a program |
| water_full | input | 1 | Drum water level has reached full |
| drain_empty | input | 1 | Drum has finished draining |
| inlet_on | output | 1 | Inlet valve enable |
| drain_on | output | 1 | Drain valve enable |
| motor_on | output | 1 | Drum motor enable |
| motor_fast | output | 1 | Motor high-speed select |
| cycle_done | output | 1 | Program completed (one cycle) |
| state_code | output | 3 | Current phase code |

## Verification
All results are due one clock edge after the input that causes them. A `start` in idle, a sensor in its own phase, or the last counted cycle of a timed phase changes the state code at the next rising edge. The outputs are decoded from that register in the same cycle. The bench drives its inputs just after a falling edge and compares every output at each falling edge with a behavioural model that updates at the rising edge, so every comparison sees the values settled after that edge. The bench also measures how long each timed phase lasts on the state code and compares that count with the configured duration.

// File: rtl/wash_pkg.sv
package wash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FILL    = 3'd1,
    ST_AGITATE = 3'd2,
    ST_EMPTY   = 3'd3,
    ST_RINSE   = 3'd4,
    ST_SPIN    = 3'd5,
    ST_FINISH  = 3'd6
  } wash_state_e;

  typedef struct packed {
    logic inlet;
    logic drain;
    logic motor;
    logic fast;
    logic done;
  } wash_act_t;

  // actuator pattern belonging to each phase
  function automatic wash_act_t act_for(wash_state_e s);
    wash_act_t a;
    a = '0;
    case (s)
      ST_FILL:    a.inlet = 1'b1;
      ST_AGITATE: a.motor = 1'b1;
      ST_EMPTY:   a.drain = 1'b1;
      ST_RINSE:   a.motor = 1'b1;
      ST_SPIN:    begin a.motor = 1'b1; a.fast = 1'b1; end
      ST_FINISH:  a.done  = 1'b1;
      default:    a = '0;
    endcase
    return a;
  endfunction

  // phases that leave on the counter rather than a sensor
  function automatic logic is_timed(wash_state_e s);
    return (s == ST_AGITATE) || (s == ST_RINSE) || (s == ST_SPIN);
  endfunction

  // cycle budget of a timed phase (1 for the others)
  function automatic int unsigned phase_len(wash_state_e s, int unsigned w,
                                            int unsigned r, int unsigned sp);
    case (s)
      ST_AGITATE: return w;
      ST_RINSE:   return r;
      ST_SPIN:    return sp;
      default:    return 1;
    endcase
  endfunction

endpackage

// File: rtl/wash_phase_timer.sv
module wash_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (cnt != CNT_TOP)  cnt <= cnt + 1'b1;
  end

  // every phase entry starts from zero
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/wash_seq_fsm.sv
module wash_seq_fsm
  import wash_pkg::*;
#(
  parameter int unsigned WASH_CYC  = 200,
  parameter int unsigned RINSE_CYC = 150,
  parameter int unsigned SPIN_CYC  = 300,
  parameter int          CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             water_full,
  input  logic             drain_empty,
  input  logic [CNT_W-1:0] cnt,
  output wash_state_e      state,
  output logic             leave
);
  wash_state_e nxt;
  logic        timer_hit;

  assign timer_hit = is_timed(state) &&
                     (cnt == CNT_W'(phase_len(state, WASH_CYC, RINSE_CYC, SPIN_CYC) - 1));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (start)       nxt = ST_FILL;
      ST_FILL:    if (water_full)  nxt = ST_AGITATE;
      ST_AGITATE: if (timer_hit)   nxt = ST_EMPTY;
      ST_EMPTY:   if (drain_empty) nxt = ST_RINSE;
      ST_RINSE:   if (timer_hit)   nxt = ST_SPIN;
      ST_SPIN:    if (timer_hit)   nxt = ST_FINISH;
      ST_FINISH:                   nxt = ST_IDLE;
      default:                     nxt = ST_IDLE;
    endcase
  end

  assign leave = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state <= ST_FINISH);
  p_idle_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start) |=> (state == ST_FILL));
  p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));
  p_fill_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && !water_full) |=> (state == ST_FILL));
  p_fill_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && water_full) |=> (state == ST_AGITATE));
  p_wash_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AGITATE && cnt < CNT_W'(WASH_CYC - 1)) |=> (state == ST_AGITATE));
  p_drain_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMPTY && !drain_empty) |=> (state == ST_EMPTY));
  p_drain_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMPTY && drain_empty) |=> (state == ST_RINSE));
  p_rinse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RINSE && cnt < CNT_W'(RINSE_CYC - 1)) |=> (state == ST_RINSE));
  p_spin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPIN && cnt < CNT_W'(SPIN_CYC - 1)) |=> (state == ST_SPIN));
  p_end_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FINISH) |=> (state == ST_IDLE));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE && state != ST_FILL) |=> (state != ST_FILL));

endmodule

// File: rtl/wash_out_decode.sv
module wash_out_decode
  import wash_pkg::*;
(
  input  wash_state_e state,
  output logic        inlet_on,
  output logic        drain_on,
  output logic        motor_on,
  output logic        motor_fast,
  output logic        cycle_done
);
  wash_act_t act;

  assign act        = act_for(state);
  assign inlet_on   = act.inlet;
  assign drain_on   = act.drain;
  assign motor_on   = act.motor;
  assign motor_fast = act.fast;
  assign cycle_done = act.done;

endmodule

// File: rtl/wash_cycle_seq.sv
module wash_cycle_seq
  import wash_pkg::*;
#(
  parameter int unsigned WASH_CYC  = 200,
  parameter int unsigned RINSE_CYC = 150,
  parameter int unsigned SPIN_CYC  = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       water_full,
  input  logic       drain_empty,
  output logic       inlet_on,
  output logic       drain_on,
  output logic       motor_on,
  output logic       motor_fast,
  output logic       cycle_done,
  output logic [2:0] state_code
);
  localparam int unsigned LEN_WR  = (WASH_CYC > RINSE_CYC) ? WASH_CYC : RINSE_CYC;
  localparam int unsigned LEN_MAX = (LEN_WR > SPIN_CYC) ? LEN_WR : SPIN_CYC;
  localparam int          CNT_W   = $clog2(LEN_MAX + 1);

  wash_state_e      state;
  logic             leave;
  logic [CNT_W-1:0] cnt;

  wash_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (leave),
    .cnt   (cnt)
  );

  wash_seq_fsm #(
    .WASH_CYC  (WASH_CYC),
    .RINSE_CYC (RINSE_CYC),
    .SPIN_CYC  (SPIN_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .water_full  (water_full),
    .drain_empty (drain_empty),
    .cnt         (cnt),
    .state       (state),
    .leave       (leave)
  );

  wash_out_decode u_dec (
    .state      (state),
    .inlet_on   (inlet_on),
    .drain_on   (drain_on),
    .motor_on   (motor_on),
    .motor_fast (motor_fast),
    .cycle_done (cycle_done)
  );

  assign state_code = state;

  p_valves_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(inlet_on && drain_on));
  p_fast_needs_motor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    motor_fast |-> motor_on);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> !(inlet_on || drain_on || motor_on));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);

endmodule

// File: tb/test_wash_cycle_seq.sv
`timescale 1ns/1ps
module test_wash_cycle_seq;
  localparam int W = 200;
  localparam int R = 150;
  localparam int S = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, water_full = 1'b0, drain_empty = 1'b0;
  logic inlet_on, drain_on, motor_on, motor_fast, cycle_done;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  wash_cycle_seq #(.WASH_CYC(W), .RINSE_CYC(R), .SPIN_CYC(S)) i_wash_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .water_full(water_full),
    .drain_empty(drain_empty), .inlet_on(inlet_on), .drain_on(drain_on),
    .motor_on(motor_on), .motor_fast(motor_fast), .cycle_done(cycle_done),
    .state_code(state_code)
  );

  // behavioural reference: phase number and time spent in it
  int m_state = 0;
  int m_time  = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_time = 0;
    end else begin
      int n;
      n = m_state;
      if (m_state == 0 && start) n = 1;
      else if (m_state == 1 && water_full) n = 2;
      else if (m_state == 2 && m_time == W - 1) n = 3;
      else if (m_state == 3 && drain_empty) n = 4;
      else if (m_state == 4 && m_time == R - 1) n = 5;
      else if (m_state == 5 && m_time == S - 1) n = 6;
      else if (m_state == 6) n = 0;
      if (n != m_state) m_time = 0; else m_time++;
      m_state = n;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every output at each falling edge
  int prev_code = 0;
  int run_len   = 0;
  always @(negedge clk) begin
    string t;
    t = !rst_n ? "R1" : tag_of(m_state);
    check(t, "state_code", int'(state_code), m_state);
    check(!rst_n ? "R1" : "R9", "inlet_on",   int'(inlet_on),   int'(m_state == 1));
    check(!rst_n ? "R1" : "R9", "drain_on",   int'(drain_on),   int'(m_state == 3));
    check(!rst_n ? "R1" : "R9", "motor_on",   int'(motor_on),   int'(m_state >= 2 && m_state <= 5 && m_state != 3));
    check(!rst_n ? "R1" : "R9", "motor_fast", int'(motor_fast), int'(m_state == 5));
    check(!rst_n ? "R1" : "R8", "cycle_done", int'(cycle_done), int'(m_state == 6));
    // measured phase durations
    if (!rst_n) begin
      prev_code = 0; run_len = 0;
    end else if (int'(state_code) == prev_code) begin
      run_len++;
    end else begin
      if (prev_code == 2) check("R4", "wash length", run_len, W);
      if (prev_code == 4) check("R6", "rinse length", run_len, R);
      if (prev_code == 5) check("R7", "spin length", run_len, S);
      if (prev_code == 6) check("R8", "end length", run_len, 1);
      prev_code = int'(state_code);
      run_len = 1;
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_code(int code);
    int guard = 0;
    while (int'(state_code) != code && guard < 2000) begin
      step(1); guard++;
    end
    check("R1", "reached phase", int'(state_code), code);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;             // R1: reset values compared by the monitor
    step(5);                  // R2: idle holds without start
    start = 1'b1; step(1); start = 1'b0;
    step(4);                  // R3: fill waits, R10: start during fill
    start = 1'b1; step(1); start = 1'b0;
    drain_empty = 1'b1; step(1); drain_empty = 1'b0;   // R11
    water_full = 1'b1; step(1); water_full = 1'b0;
    step(20);                 // R10 and R11 during wash
    start = 1'b1; drain_empty = 1'b1; step(2); start = 1'b0; drain_empty = 1'b0;
    wait_code(3);
    step(6);                  // R5: drain waits, R11: water_full ignored
    water_full = 1'b1; start = 1'b1; step(2); water_full = 1'b0; start = 1'b0;
    drain_empty = 1'b1; step(1); drain_empty = 1'b0;
    step(30);                 // R11 during rinse
    water_full = 1'b1; drain_empty = 1'b1; step(3); water_full = 1'b0; drain_empty = 1'b0;
    wait_code(6);
    step(4);                  // R8: back to idle and stays
    // second program with both sensors held high
    water_full = 1'b1; drain_empty = 1'b1;
    start = 1'b1; step(1); start = 1'b0;
    wait_code(0);
    step(3);
    // reset in the middle of wash
    start = 1'b1; step(1); start = 1'b0;
    wait_code(2);
    step(50);
    rst_n = 1'b0; step(2);
    rst_n = 1'b1; step(1);
    check("R1", "state after reset", int'(state_code), 0);
    check("R1", "outputs after reset",
          int'({inlet_on, drain_on, motor_on, motor_fast, cycle_done}), 0);
    water_full = 1'b0; drain_empty = 1'b0;
    step(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule